// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a four-channel simultaneous-sampling data-acquisition converter. Each channel has two selectable inputs, so there are eight inputs in total, split into bank A and bank B. A host writes a 4-bit control word on the low bits of a parallel bus using chip-select and write strobes. The word picks the input bank and sets how many channels, from one to four, are converted each time a start pulse arrives. It can also place the block in power-down. On the rising edge of the start input, all four held values of the selected bank are captured in the same clock cycle. The sequencer then converts channel 1 upward, one channel after another. Each conversion is modelled as a fixed number of clocks, after which the held value is written into a four-entry result memory.

When the last channel is done, the block pulls its active-low interrupt output low. The host then reads the results with read strobes. The memory has no address input: a pointer starts at channel 1, moves forward at the end of every read and returns to channel 1 after the programmed number of reads, so further reads repeat the same results. The first read of a sequence releases the interrupt. The programmed mode stays in force across start pulses until the host writes a new one.

The bus is split into an input nibble, a 14-bit output word and an output-enable flag. The enable stands in for the tri-state control of the pad.

Top module: `sps_seq_ctrl`

## Requirements
- R1: After reset the interrupt output is high, the output enable is low, and the mode is bank A with one channel.
- R2: Control word bit 3 set means power-down. With bit 3 clear, bit 2 selects the bank (0 = A, 1 = B) and bits 1:0 hold the channel count minus one (0 = one channel, 3 = four channels).
- R3: A write is accepted only while chip-select is low. The word takes effect when the write strobe or the chip-select rises, whichever rises first.
- R4: In idle, a rising start edge captures all four inputs of the selected bank in one clock. Later input changes do not alter the results of that sequence.
- R5: Channels are converted in order from channel 1, each taking CONV_CYCLES clocks. Count the clock edge that sees the start edge as edge 0. The interrupt falls after edge n*CONV_CYCLES+1, where n is the channel count.
- R6: Start edges seen while a sequence is running are ignored.
- R7: The interrupt returns high on the clock edge that first sees read and chip-select both low.
- R8: Reads begin at channel 1. The pointer moves forward when a read ends and wraps to channel 1 after n reads, so extra reads cycle through the results.
- R9: While chip-select is high, read and write strobes have no effect and the output enable is low. Chip-select may stay low across several reads.
- R10: Results are 14-bit two's-complement words, bit 13 being the MSB. They are returned unchanged, including both extreme values.
- R11: A power-down write takes effect at its commit edge. In power-down, start edges are ignored and the interrupt stays high. A later write with bit 3 clear wakes the block into the mode given by bits 2:0.
- R12: The mode persists: repeated start pulses with no write in between use the same bank and channel count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| convst | input | 1 | Start input, rising edge samples and starts |
| ctl_in | input | 4 | Control nibble from the bus |
| ain_a | input | 56 | Bank A held values, channel c at bits 14c+13..14c |
| ain_b | input | 56 | Bank B held values, same packing |
| data_out | output | 14 | Result word at the read pointer, zero when not driven |
| data_oe | output | 1 | Bus drive enable, high during a selected read |
| int_n | output | 1 | End-of-sequence interrupt, active low |

## Verification
The interrupt is due exactly n*CONV_CYCLES+2 falling clock edges after the bench raises the start input. This count covers the edge-detect register, the n conversion windows, the completion state and the output register. The bench counts those edges and compares the count with the expected value for every channel count. The output enable and the read data follow the strobes within the same cycle, and the pointer moves one edge after a read ends. The bench's behavioural model applies each input on the same edges and is compared with the outputs on every falling edge, away from the edges where the design's state changes.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_DONE  = 2'd2,
        ST_PDOWN = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       pdown;
        logic       bank_b;
        logic [1:0] last_ch;
    } mode_word_t;

    localparam mode_word_t MODE_DEFAULT = '{pdown: 1'b0, bank_b: 1'b0, last_ch: 2'd0};

endpackage

// File: rtl/sps_strobe_front.sv
module sps_strobe_front #(
    parameter int CTL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             convst,
    input  logic [CTL_W-1:0] ctl_in,
    output logic             wr_commit,
    output logic [CTL_W-1:0] ctl_word,
    output logic             rd_start,
    output logic             rd_end,
    output logic             cv_rise
);

    logic             wr_act;
    logic             rd_act;
    logic             wr_act_q;
    logic             rd_act_q;
    logic             cv_q;
    logic [CTL_W-1:0] ctl_cap_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            rd_act_q  <= 1'b0;
            cv_q      <= 1'b1;
            ctl_cap_q <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            cv_q     <= convst;
            if (wr_act) begin
                ctl_cap_q <= ctl_in;
            end
        end
    end

    // the first of the two strobes to rise ends the write
    assign wr_commit = wr_act_q && !wr_act;
    assign ctl_word  = ctl_cap_q;
    assign rd_start  = rd_act && !rd_act_q;
    assign rd_end    = rd_act_q && !rd_act;
    assign cv_rise   = convst && !cv_q;

    AST_COMMIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(!cs_n) && $past(!wr_n))); // R3

endmodule

// File: rtl/sps_track_hold.sv
module sps_track_hold #(
    parameter int DATA_W = 14,
    parameter int N_CH   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic                   bank_b,
    input  logic [N_CH*DATA_W-1:0] ain_a,
    input  logic [N_CH*DATA_W-1:0] ain_b,
    output logic [N_CH*DATA_W-1:0] held
);

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            logic [DATA_W-1:0] hold_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hold_q <= '0;
                end else if (capture) begin
                    hold_q <= bank_b ? ain_b[c*DATA_W +: DATA_W]
                                     : ain_a[c*DATA_W +: DATA_W];
                end
            end

            assign held[c*DATA_W +: DATA_W] = hold_q;
        end
    endgenerate

endmodule

// File: rtl/sps_conv_model.sv
module sps_conv_model #(
    parameter int DATA_W      = 14,
    parameter int N_CH        = 4,
    parameter int CH_W        = 2,
    parameter int CONV_CYCLES = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   busy,
    input  logic [CH_W-1:0]        chan,
    input  logic [N_CH*DATA_W-1:0] held,
    output logic                   step_done,
    output logic [DATA_W-1:0]      result
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!busy || cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign step_done = busy && (cnt_q == CNT_LAST);
    assign result    = held[int'(chan)*DATA_W +: DATA_W];

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> cnt_q == '0); // R5

endmodule

// File: rtl/sps_result_mem.sv
module sps_result_mem #(
    parameter int DATA_W = 14,
    parameter int N_CH   = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [CH_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CH_W-1:0]   raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [N_CH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sps_seq_ctrl.sv
module sps_seq_ctrl
    import sps_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int N_CH        = 4,
    parameter int CONV_CYCLES = 48,
    parameter int CTL_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   wr_n,
    input  logic                   rd_n,
    input  logic                   convst,
    input  logic [CTL_W-1:0]       ctl_in,
    input  logic [N_CH*DATA_W-1:0] ain_a,
    input  logic [N_CH*DATA_W-1:0] ain_b,
    output logic [DATA_W-1:0]      data_out,
    output logic                   data_oe,
    output logic                   int_n
);

    localparam int CH_W = $clog2(N_CH);

    seq_state_t        state_q, state_d;
    mode_word_t        mode_q, new_mode;
    logic [CH_W-1:0]   chan_q, seq_last_q, rd_ptr_q;
    logic              int_q;

    logic              wr_commit, rd_start, rd_end, cv_rise;
    logic [CTL_W-1:0]  ctl_word;
    logic              pd_cmd, wake_cmd, start;
    logic              step_done, last_step;
    logic [N_CH*DATA_W-1:0] held;
    logic [DATA_W-1:0] result, rdata;

    sps_strobe_front #(.CTL_W(CTL_W)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .convst(convst), .ctl_in(ctl_in), .wr_commit(wr_commit),
        .ctl_word(ctl_word), .rd_start(rd_start), .rd_end(rd_end),
        .cv_rise(cv_rise)
    );

    assign new_mode  = mode_word_t'(ctl_word);
    assign pd_cmd    = wr_commit && new_mode.pdown;
    assign wake_cmd  = wr_commit && !new_mode.pdown;
    assign start     = (state_q == ST_IDLE) && cv_rise && !pd_cmd;
    assign last_step = step_done && (chan_q == seq_last_q);

    sps_track_hold #(.DATA_W(DATA_W), .N_CH(N_CH)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(start), .bank_b(mode_q.bank_b),
        .ain_a(ain_a), .ain_b(ain_b), .held(held)
    );

    sps_conv_model #(.DATA_W(DATA_W), .N_CH(N_CH), .CH_W(CH_W),
                     .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk(clk), .rst_n(rst_n), .busy(state_q == ST_CONV), .chan(chan_q),
        .held(held), .step_done(step_done), .result(result)
    );

    sps_result_mem #(.DATA_W(DATA_W), .N_CH(N_CH), .CH_W(CH_W)) u_mem (
        .clk(clk), .we(step_done), .waddr(chan_q), .wdata(result),
        .raddr(rd_ptr_q), .rdata(rdata)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pd_cmd) state_d = ST_PDOWN;
                      else if (cv_rise) state_d = ST_CONV;
            ST_CONV:  if (pd_cmd) state_d = ST_PDOWN;
                      else if (last_step) state_d = ST_DONE;
            ST_DONE:  if (pd_cmd) state_d = ST_PDOWN;
                      else state_d = ST_IDLE;
            ST_PDOWN: if (wake_cmd) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_DEFAULT;
            chan_q     <= '0;
            seq_last_q <= '0;
            rd_ptr_q   <= '0;
            int_q      <= 1'b1;
        end else begin
            if (wake_cmd) begin
                mode_q <= new_mode;
            end
            if (start) begin
                chan_q     <= '0;
                seq_last_q <= CH_W'(mode_q.last_ch);
            end else if (step_done && !last_step) begin
                chan_q <= chan_q + 1'b1;
            end
            if (state_q == ST_DONE && !pd_cmd) begin
                int_q <= 1'b0;
            end else if (rd_start) begin
                int_q <= 1'b1;
            end
            if (state_q == ST_DONE) begin
                rd_ptr_q <= '0;
            end else if (rd_end) begin
                rd_ptr_q <= (rd_ptr_q == seq_last_q) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    end

    assign int_n    = int_q;
    assign data_oe  = !cs_n && !rd_n;
    assign data_out = data_oe ? rdata : '0;

    AST_INT_FALLS_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(state_q == ST_DONE)); // R5

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !step_done && !pd_cmd)
            |=> (state_q == ST_CONV && $stable(chan_q) && $stable(seq_last_q))); // R6

    AST_CHAN_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && step_done && !last_step && !pd_cmd)
            |=> chan_q == $past(chan_q) + 1'b1); // R5

    AST_PTR_HOME_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |=> rd_ptr_q == '0); // R8

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_q <= seq_last_q); // R8

    AST_PDOWN_KEEPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PDOWN && int_n) |=> int_n); // R11

endmodule

// File: tb/sps_seq_ctrl_tb.sv
module sps_seq_ctrl_tb;

    localparam int DW   = 14;
    localparam int NC   = 4;
    localparam int NCYC = 48;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, convst = 1'b1;
    logic [3:0]    ctl_in = 4'h0;
    logic [NC*DW-1:0] ain_a = '0, ain_b = '0;
    logic [DW-1:0] data_out;
    logic          data_oe, int_n;

    int vec = 0;
    int bad = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    sps_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .convst(convst), .ctl_in(ctl_in), .ain_a(ain_a), .ain_b(ain_b),
        .data_out(data_out), .data_oe(data_oe), .int_n(int_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic          m_int;
    int            m_ptr, m_last, m_end, m_cnt_mode;
    bit            m_pd, m_bank, m_busy;
    bit            p_wr, p_rd, p_cv;
    logic [3:0]    m_cap;
    logic [DW-1:0] m_mem [NC];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_int = 1'b1; m_ptr = 0; m_last = 0; m_end = 0; m_cnt_mode = 0;
            m_pd = 0; m_bank = 0; m_busy = 0;
            p_wr = 0; p_rd = 0; p_cv = 1; m_cap = 4'h0;
            cyc = 0;
        end else begin : model_step
            bit wa, ra, commit, rstart, rend, rise, idle;
            wa = !cs_n && !wr_n;
            ra = !cs_n && !rd_n;
            commit = p_wr && !wa;
            rstart = ra && !p_rd;
            rend   = p_rd && !ra;
            rise   = convst && !p_cv;
            idle   = !m_busy && !m_pd;
            cyc++;
            if (rstart) m_int = 1'b1;
            if (rend) m_ptr = (m_ptr == m_last) ? 0 : m_ptr + 1;
            if (m_busy && cyc == m_end) begin
                m_busy = 0; m_int = 1'b0; m_ptr = 0;
            end
            if (idle && rise && !(commit && m_cap[3])) begin
                for (int k = 0; k <= m_cnt_mode; k++)
                    m_mem[k] = m_bank ? ain_b[k*DW +: DW] : ain_a[k*DW +: DW];
                m_last = m_cnt_mode;
                m_busy = 1;
                m_end  = cyc + (m_cnt_mode + 1) * NCYC + 1;
            end
            if (commit) begin
                if (m_cap[3]) begin
                    m_pd = 1; m_busy = 0;
                end else begin
                    m_pd = 0; m_bank = m_cap[2]; m_cnt_mode = int'(m_cap[1:0]);
                end
            end
            if (wa) m_cap = ctl_in;
            p_wr = wa; p_rd = ra; p_cv = convst;
        end
    end

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R5 int_n vs model", int_n, m_int);
            chk("R9 data_oe vs model", data_oe, !cs_n && !rd_n);
            if (data_oe && !$isunknown(m_mem[m_ptr]))
                chk("R8 data_out vs model", data_out, m_mem[m_ptr]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [3:0] w, input bit end_by_cs, input bit selected);
        ctl_in = w;
        cs_n = !selected;
        tick(1);
        wr_n = 1'b0;
        tick(2);
        if (end_by_cs) begin
            cs_n = 1'b1; tick(1); wr_n = 1'b1;
        end else begin
            wr_n = 1'b1; tick(1); cs_n = 1'b1;
        end
        tick(2);
    endtask

    // raise start, return falling edges until int_n goes low
    task automatic run_seq(input bit disturb, output int edges);
        convst = 1'b0;
        tick(2);
        convst = 1'b1;
        edges = 0;
        while (int_n && edges < 1000) begin
            @(negedge clk);
            edges++;
            if (disturb && edges == 5) begin
                ain_a = ~ain_a; ain_b = ~ain_b;
            end
            if (disturb && edges == 20) convst = 1'b0;
            if (disturb && edges == 23) convst = 1'b1;
        end
    endtask

    task automatic read_word(output logic [DW-1:0] v);
        rd_n = 1'b0;
        tick(1);
        v = data_out;
        rd_n = 1'b1;
        tick(1);
    endtask

    function automatic logic [NC*DW-1:0] pack4(input logic [DW-1:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    // ---------------- directed sequence ----------------
    initial begin : main
        logic [DW-1:0] v;
        logic [NC*DW-1:0] snap_a, snap_b;
        int e;

        tick(3);
        chk("R1 int_n after reset", int_n, 1'b1);
        chk("R1 data_oe after reset", data_oe, 1'b0);
        rst_n = 1'b1;
        tick(2);

        // default mode: bank A, one channel
        ain_a = pack4(14'h0123, 14'h0456, 14'h0789, 14'h0ABC);
        ain_b = pack4(14'h1111, 14'h2222, 14'h3333, 14'h1444);
        run_seq(1'b0, e);
        chk("R1 R5 one-channel latency", e, 1 * NCYC + 2);
        cs_n = 1'b0;
        read_word(v);
        chk("R7 int_n released by read", int_n, 1'b1);
        chk("R1 default bank A CH1", v, 14'h0123);
        read_word(v);
        chk("R8 wrap after one read", v, 14'h0123);
        cs_n = 1'b1;
        tick(2);

        // four channels bank A, write ended by WR
        write_ctl(4'b0011, 1'b0, 1'b1);
        ain_a = pack4(14'h2000, 14'h1FFF, 14'h3FFF, 14'h0001);
        snap_a = ain_a;
        run_seq(1'b1, e);
        chk("R5 R6 four-channel latency", e, 4 * NCYC + 2);
        cs_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            read_word(v);
            chk("R4 R10 held result", v, snap_a[k*DW +: DW]);
        end
        read_word(v);
        chk("R8 wrap to CH1", v, snap_a[DW-1:0]);
        cs_n = 1'b1;
        tick(2);

        // bank B, three channels, write ended by CS
        write_ctl(4'b0110, 1'b1, 1'b1);
        snap_b = ain_b;
        run_seq(1'b0, e);
        chk("R2 R3 three-channel latency", e, 3 * NCYC + 2);
        cs_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            read_word(v);
            chk("R2 bank B result", v, snap_b[k*DW +: DW]);
        end
        read_word(v);
        chk("R8 wrap after three", v, snap_b[DW-1:0]);
        cs_n = 1'b1;
        tick(2);

        // write and read with CS high are ignored; mode persists
        write_ctl(4'b0000, 1'b0, 1'b0);
        snap_b = ain_b;
        run_seq(1'b0, e);
        chk("R9 R12 deselected write ignored", e, 3 * NCYC + 2);
        rd_n = 1'b0; tick(1);
        chk("R9 bus idle while deselected", data_oe, 1'b0);
        rd_n = 1'b1; tick(1);
        chk("R9 deselected read keeps int", int_n, 1'b0);
        cs_n = 1'b0;
        read_word(v);
        chk("R9 pointer unmoved by deselected read", v, snap_b[DW-1:0]);
        cs_n = 1'b1;
        tick(2);

        // power-down, start ignored, then wake into bank A two channels
        write_ctl(4'b1000, 1'b0, 1'b1);
        run_seq(1'b0, e);
        chk("R11 start ignored in power-down", int_n, 1'b1);
        write_ctl(4'b0001, 1'b0, 1'b1);
        ain_a = pack4(14'h2ABC, 14'h1DEF, 14'h0000, 14'h0000);
        snap_a = ain_a;
        run_seq(1'b0, e);
        chk("R11 wake two-channel latency", e, 2 * NCYC + 2);
        cs_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            read_word(v);
            chk("R11 woken mode result", v, snap_a[(k % 2)*DW +: DW]);
        end
        cs_n = 1'b1;
        tick(2);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        done_flag = 1'b1;
        bad++;
        vec++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule